// File: doc/BRIEF.md
# Nonvolatile Memory Write Controller

This block is the register front end that launches write and erase operations on on-chip nonvolatile storage. Software reaches it over a small synchronous register bus: a control register, a key register with no storage, a byte-wide data latch, a 22-bit address pointer split over three byte registers, and a window onto an eight-byte holding buffer. Storing to the window places the data latch into the holding byte picked by the pointer's three low bits. The array itself is touched only when a separate operation is started.

An operation starts only after two key bytes are written to the key register on back-to-back bus writes, and only while write-enable is already set. The operation then runs for a fixed number of cycles, during which the block drives the target select, address, data and a write or erase strobe toward the array. All software-visible state is frozen while it runs. When it ends, hardware clears the start bit and sets a sticky completion flag. A warm reset (external pin or watchdog) that lands during an operation leaves an error flag set, and that flag survives the warm reset.

Top module: `nvm_write_ctrl`

## Requirements
- R1: A bus write to address 3 stores the data latch (address 2) into holding byte pointer[2:0]. A read of address 3 returns that holding byte. The store raises neither mem_wr nor mem_erase.
- R2: A read of the key register (address 1) always returns 0x00.
- R3: mem_tgt is 2 (configuration) when ctrl bit 6 is 1, whatever ctrl bit 7 holds. Otherwise it is 1 (program) when bit 7 is 1 and 0 (data) when bit 7 is 0. For data and configuration targets, mem_addr is the full pointer and mem_wdata is the data latch zero-extended.
- R4: While busy, mem_erase is high if ctrl bit 4 was 1 when the operation started. Otherwise mem_wr is high. The two are never high together.
- R5: A control write with bit 1 set starts an operation only when write-enable (ctrl bit 2) was already 1 and the two previous bus writes were 0x55 and then 0xAA to address 1. Any other bus write in between cancels the key sequence.
- R6: mem_busy and ctrl bit 1 read 1 for exactly OP_CYCLES cycles after the start write, then return to 0 by themselves. Writing 0 to bit 1 cannot end an operation.
- R7: done_irq (ctrl bit 5) is set when an operation completes. Writing 1 to bit 5 leaves it unchanged, and only writing 0 clears it.
- R8: A warm reset during an operation sets the error flag (ctrl bit 3). The flag stays readable after the reset and is cleared only by writing 0 to bit 3. A warm reset zeroes the data latch, the pointer and the control fields. A warm reset while idle leaves the error flag clear.
- R9: While busy, bus writes to the control register, data latch, pointer and holding buffer are ignored.
- R10: A program-target write drives mem_addr as the pointer with bits [2:0] cleared and mem_wdata as the eight holding bytes, with byte i in bits [8i+7:8i]. Once it completes, every holding byte reads 0xFF.
- R11: After power-up reset, ctrl reads 0x00, so write-enable is 0, the latch reads 0x00 and the holding bytes read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, asynchronous, active low |
| warm_rst_n | input | 1 | Warm reset (external or watchdog), sampled on clk, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 ctrl, 1 key, 2 latch, 3 holding window, 4..6 pointer bytes low to high |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr, combinational |
| mem_tgt | output | 2 | Array target: 0 data, 1 program, 2 configuration |
| mem_addr | output | 22 | Array address |
| mem_wdata | output | 64 | Array write data |
| mem_wr | output | 1 | Write request, high for the whole operation |
| mem_erase | output | 1 | Erase request, high for the whole operation |
| mem_busy | output | 1 | Operation in progress |
| done_irq | output | 1 | Sticky completion flag |

## Verification
Register writes take effect on the clock edge that samples them, and reads are combinational, so a read-back check is due in the cycle after the write. A start write raises mem_busy and the request strobes in the next cycle. The strobes hold for OP_CYCLES cycles, and the completion flag and the refilled holding buffer appear on the same edge that drops busy. The driver counts every edge its tasks consume, so each expected item is sampled at the falling edge of the exact cycle it is due. The full-length check samples busy at the last high cycle and again at the first low cycle. A warm reset is applied on one edge, and the error flag and the zeroed registers are read in the cycle after it.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    TGT_DATA = 2'd0,
    TGT_PROG = 2'd1,
    TGT_CFG  = 2'd2
  } nvm_tgt_e;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_HALF = 2'd1,
    UL_OPEN = 2'd2
  } ul_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_KEY   = 3'd1;
  localparam logic [2:0] RA_LATCH = 3'd2;
  localparam logic [2:0] RA_TBL   = 3'd3;
  localparam int         RA_PTR0  = 4;

  localparam int CB_PGM   = 7;
  localparam int CB_CFG   = 6;
  localparam int CB_DONE  = 5;
  localparam int CB_ERASE = 4;
  localparam int CB_ERR   = 3;
  localparam int CB_WEN   = 2;
  localparam int CB_GO    = 1;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       clr,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       open_o
);
  ul_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clr) begin
      state_d = UL_IDLE;
    end else if (wr_en) begin
      if (wr_addr == RA_KEY && wr_data == KEY_FIRST)
        state_d = UL_HALF;
      else if (state_q == UL_HALF && wr_addr == RA_KEY && wr_data == KEY_SECOND)
        state_d = UL_OPEN;
      else
        state_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == UL_OPEN);
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int OP_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic start,
  output logic busy_o,
  output logic fin_o
);
  localparam int CW = (OP_CYCLES > 2) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(OP_CYCLES - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign fin_o  = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (clr) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/nvm_hold_buf.sv
module nvm_hold_buf #(
  parameter int NB = 8,
  localparam int SW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          fill_ones,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [7:0]    wr_data,
  input  logic [SW-1:0] rd_sel,
  output logic [7:0]    rd_data,
  output logic [NB*8-1:0] flat_o
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] b_q, b_d;

    always_comb begin
      b_d = b_q;
      if (fill_ones)
        b_d = 8'hFF;
      else if (wr_en && wr_sel == SW'(g))
        b_d = wr_data;
    end

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) b_q <= 8'hFF;
      else        b_q <= b_d;
    end

    assign flat_o[g*8 +: 8] = b_q;
  end

  assign rd_data = flat_o[rd_sel*8 +: 8];
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
  import nvm_pkg::*;
#(
  parameter int PTR_W      = 22,
  parameter int HOLD_BYTES = 8,
  parameter int OP_CYCLES  = 16
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    warm_rst_n,
  input  logic                    bus_we,
  input  logic [2:0]              bus_addr,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic [1:0]              mem_tgt,
  output logic [PTR_W-1:0]        mem_addr,
  output logic [HOLD_BYTES*8-1:0] mem_wdata,
  output logic                    mem_wr,
  output logic                    mem_erase,
  output logic                    mem_busy,
  output logic                    done_irq
);
  localparam int SW        = $clog2(HOLD_BYTES);
  localparam int PTR_BYTES = (PTR_W + 7) / 8;
  localparam int HW        = HOLD_BYTES * 8;

  logic pgm_q, pgm_d, cfg_q, cfg_d, ers_q, ers_d, wen_q, wen_d;
  logic err_q, err_d, done_q, done_d;
  logic [7:0]       latch_q, latch_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_BYTES*8-1:0] ptr_pad_w, ptr_pad_r;

  logic busy, fin, key_open, wr_ok, ctrl_wr, start_go, tbl_wr, refill;
  logic [7:0] hold_rd;
  logic [HW-1:0] hold_flat;
  nvm_tgt_e tgt;

  assign wr_ok    = bus_we && warm_rst_n && !busy;
  assign ctrl_wr  = wr_ok && (bus_addr == RA_CTRL);
  assign tbl_wr   = wr_ok && (bus_addr == RA_TBL);
  assign start_go = ctrl_wr && bus_wdata[CB_GO] && wen_q && key_open;
  assign refill   = !warm_rst_n || (fin && !ers_q && tgt == TGT_PROG);

  nvm_unlock u_unlock (
    .clk     (clk),
    .por_n   (por_n),
    .clr     (!warm_rst_n),
    .wr_en   (bus_we),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .open_o  (key_open)
  );

  nvm_op_timer #(.OP_CYCLES(OP_CYCLES)) u_timer (
    .clk    (clk),
    .por_n  (por_n),
    .clr    (!warm_rst_n),
    .start  (start_go),
    .busy_o (busy),
    .fin_o  (fin)
  );

  nvm_hold_buf #(.NB(HOLD_BYTES)) u_hold (
    .clk       (clk),
    .por_n     (por_n),
    .fill_ones (refill),
    .wr_en     (tbl_wr),
    .wr_sel    (ptr_q[SW-1:0]),
    .wr_data   (latch_q),
    .rd_sel    (ptr_q[SW-1:0]),
    .rd_data   (hold_rd),
    .flat_o    (hold_flat)
  );

  // Target decode: configuration select overrides program/data select.
  always_comb begin
    if (cfg_q)      tgt = TGT_CFG;
    else if (pgm_q) tgt = TGT_PROG;
    else            tgt = TGT_DATA;
  end

  // Next state of the software-visible registers.
  always_comb begin
    pgm_d   = pgm_q;
    cfg_d   = cfg_q;
    ers_d   = ers_q;
    wen_d   = wen_q;
    err_d   = err_q;
    done_d  = done_q;
    latch_d = latch_q;
    ptr_pad_w = '0;
    ptr_pad_w[PTR_W-1:0] = ptr_q;
    if (!warm_rst_n) begin
      pgm_d   = 1'b0;
      cfg_d   = 1'b0;
      ers_d   = 1'b0;
      wen_d   = 1'b0;
      latch_d = '0;
      ptr_pad_w = '0;
      err_d   = err_q | busy;
    end else begin
      if (ctrl_wr) begin
        pgm_d = bus_wdata[CB_PGM];
        cfg_d = bus_wdata[CB_CFG];
        ers_d = bus_wdata[CB_ERASE];
        wen_d = bus_wdata[CB_WEN];
        if (!bus_wdata[CB_ERR])  err_d  = 1'b0;
        if (!bus_wdata[CB_DONE]) done_d = 1'b0;
      end
      if (fin) done_d = 1'b1;
      if (wr_ok && bus_addr == RA_LATCH) latch_d = bus_wdata;
      for (int b = 0; b < PTR_BYTES; b++) begin
        if (wr_ok && bus_addr == 3'(RA_PTR0 + b))
          ptr_pad_w[b*8 +: 8] = bus_wdata;
      end
    end
    ptr_d = ptr_pad_w[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pgm_q   <= 1'b0;
      cfg_q   <= 1'b0;
      ers_q   <= 1'b0;
      wen_q   <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      latch_q <= '0;
      ptr_q   <= '0;
    end else begin
      pgm_q   <= pgm_d;
      cfg_q   <= cfg_d;
      ers_q   <= ers_d;
      wen_q   <= wen_d;
      err_q   <= err_d;
      done_q  <= done_d;
      latch_q <= latch_d;
      ptr_q   <= ptr_d;
    end
  end

  // Register read mux.
  always_comb begin
    ptr_pad_r = '0;
    ptr_pad_r[PTR_W-1:0] = ptr_q;
    bus_rdata = 8'h00;
    case (bus_addr)
      RA_CTRL:  bus_rdata = {pgm_q, cfg_q, done_q, ers_q, err_q, wen_q, busy, 1'b0};
      RA_KEY:   bus_rdata = 8'h00;
      RA_LATCH: bus_rdata = latch_q;
      RA_TBL:   bus_rdata = hold_rd;
      default: begin
        for (int b = 0; b < PTR_BYTES; b++) begin
          if (bus_addr == 3'(RA_PTR0 + b)) bus_rdata = ptr_pad_r[b*8 +: 8];
        end
      end
    endcase
  end

  // Array request side.
  always_comb begin
    mem_tgt = tgt;
    if (tgt == TGT_PROG) begin
      mem_addr  = {ptr_q[PTR_W-1:SW], {SW{1'b0}}};
      mem_wdata = hold_flat;
    end else begin
      mem_addr  = ptr_q;
      mem_wdata = {{(HW-8){1'b0}}, latch_q};
    end
  end

  assign mem_busy  = busy;
  assign mem_wr    = busy && !ers_q;
  assign mem_erase = busy && ers_q;
  assign done_irq  = done_q;
endmodule

// File: rtl/nvm_write_ctrl_chk.sv
module nvm_write_ctrl_chk #(
  parameter int PTR_W     = 22,
  parameter int OP_CYCLES = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             warm_rst_n,
  input logic             mem_busy,
  input logic             mem_wr,
  input logic             mem_erase,
  input logic [1:0]       mem_tgt,
  input logic [PTR_W-1:0] mem_addr,
  input logic             done_irq,
  input logic             err_q
);
  logic [31:0] run_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        run_cnt <= '0;
    else if (mem_busy) run_cnt <= run_cnt + 1'b1;
    else               run_cnt <= '0;
  end

  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!por_n)
    !(mem_wr && mem_erase));

  a_r4_strobe_busy: assert property (@(posedge clk) disable iff (!por_n)
    (mem_wr || mem_erase) == mem_busy);

  a_r6_runs_on: assert property (@(posedge clk) disable iff (!por_n)
    (mem_busy && warm_rst_n && run_cnt < 32'(OP_CYCLES - 1)) |=> mem_busy);

  a_r6_ends: assert property (@(posedge clk) disable iff (!por_n)
    (mem_busy && run_cnt == 32'(OP_CYCLES - 1)) |=> !mem_busy);

  a_r7_done_on_finish: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(mem_busy) && $past(warm_rst_n)) |-> done_irq);

  a_r8_err_capture: assert property (@(posedge clk) disable iff (!por_n)
    (!warm_rst_n && mem_busy) |=> err_q);

  a_r9_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (mem_busy && warm_rst_n) |=> (!mem_busy || ($stable(mem_addr) && $stable(mem_tgt))));
endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk #(.PTR_W(PTR_W), .OP_CYCLES(OP_CYCLES)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .warm_rst_n (warm_rst_n),
  .mem_busy   (mem_busy),
  .mem_wr     (mem_wr),
  .mem_erase  (mem_erase),
  .mem_tgt    (mem_tgt),
  .mem_addr   (mem_addr),
  .done_irq   (done_irq),
  .err_q      (err_q)
);

// File: tb/test_nvm_write_ctrl.sv
module test_nvm_write_ctrl;
  localparam int OPC = 16;
  localparam int K_RD = 0, K_BUSY = 1, K_TGT = 2, K_WR = 3, K_ERS = 4,
                 K_ADDR = 5, K_WDAT = 6, K_IRQ = 7;

  logic        clk, por_n, warm_rst_n, bus_we;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [1:0]  mem_tgt;
  logic [21:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_wr, mem_erase, mem_busy, done_irq;

  int total = 0, bad = 0;
  bit finished = 0;

  typedef struct {
    int          kind;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t sq[$];
  item_t it;
  logic [63:0] act;

  nvm_write_ctrl #(.OP_CYCLES(OPC)) i_nvm_write_ctrl (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_tgt(mem_tgt), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wr(mem_wr), .mem_erase(mem_erase), .mem_busy(mem_busy), .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Monitor: pops expected items at the falling edge.
  always @(negedge clk) begin
    if (sq.size() > 0) begin
      it = sq.pop_front();
      case (it.kind)
        K_RD:    act = {56'b0, bus_rdata};
        K_BUSY:  act = {63'b0, mem_busy};
        K_TGT:   act = {62'b0, mem_tgt};
        K_WR:    act = {63'b0, mem_wr};
        K_ERS:   act = {63'b0, mem_erase};
        K_ADDR:  act = {42'b0, mem_addr};
        K_WDAT:  act = mem_wdata;
        default: act = {63'b0, done_irq};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t x;
    @(posedge clk); #1;
    bus_addr = a;
    x.kind = K_RD; x.exp = {56'b0, e}; x.tag = tag;
    sq.push_back(x);
  endtask

  task automatic pin(input int k, input logic [63:0] e, input string tag);
    item_t x;
    @(posedge clk); #1;
    x.kind = k; x.exp = e; x.tag = tag;
    sq.push_back(x);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic unlock_go(input logic [7:0] ctrl);
    wr(3'd1, 8'h55);
    wr(3'd1, 8'hAA);
    wr(3'd0, ctrl);
  endtask

  task automatic warm_pulse();
    @(posedge clk); #1;
    warm_rst_n = 1'b0;
    @(posedge clk); #1;
    warm_rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200; n++) begin
      @(posedge clk); #1;
      if (!mem_busy) break;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; warm_rst_n = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1;

    // R11 reset state
    rd(3'd0, 8'h00, "R11 ctrl after power-up");
    rd(3'd2, 8'h00, "R11 latch after power-up");
    rd(3'd3, 8'hFF, "R11 holding byte after power-up");
    rd(3'd1, 8'h00, "R2 key register reads zero");
    pin(K_BUSY, 0, "R11 idle after power-up");

    // R1 table write into holding buffer
    wr(3'd0, 8'h04);
    rd(3'd0, 8'h04, "R5 write-enable set");
    wr(3'd2, 8'h3C);
    wr(3'd4, 8'h45); wr(3'd5, 8'h23); wr(3'd6, 8'h01);
    wr(3'd3, 8'h00);
    rd(3'd3, 8'h3C, "R1 holding byte 5 stored");
    pin(K_WR, 0, "R1 no array write on table store");
    rd(3'd1, 8'h00, "R2 key register still zero");
    for (int i = 0; i < 8; i++) begin
      wr(3'd4, 8'h48 + 8'(i));
      wr(3'd2, 8'h10 + 8'(i));
      wr(3'd3, 8'h00);
    end
    wr(3'd4, 8'h4D);
    rd(3'd3, 8'h15, "R1 holding byte picked by pointer low bits");

    // R5 negative cases
    wr(3'd0, 8'h86);
    pin(K_BUSY, 0, "R5 start without key sequence");
    wr(3'd1, 8'h55); wr(3'd0, 8'h84); wr(3'd1, 8'hAA); wr(3'd0, 8'h86);
    pin(K_BUSY, 0, "R5 interrupted key sequence");
    wr(3'd0, 8'h80);
    unlock_go(8'h86);
    pin(K_BUSY, 0, "R5 write-enable was clear");
    rd(3'd0, 8'h84, "R5 rejected start leaves bit1 clear");

    // R10 program write, R9 ignored writes while busy
    unlock_go(8'h86);
    pin(K_BUSY, 1, "R5 start accepted");
    pin(K_TGT, 1, "R3 program target");
    pin(K_WR, 1, "R4 write strobe");
    pin(K_ADDR, 64'h012348, "R10 aligned address");
    pin(K_WDAT, 64'h1716151413121110, "R10 holding bytes to array");
    rd(3'd0, 8'h86, "R6 start reads one while busy");
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h99);
    wr(3'd3, 8'h00);
    rd(3'd0, 8'h86, "R6 R9 software cannot clear start");
    rd(3'd2, 8'h17, "R9 latch write ignored while busy");
    wait_idle();
    rd(3'd0, 8'hA4, "R7 done set after program write");
    pin(K_IRQ, 1, "R7 done_irq high");
    rd(3'd3, 8'hFF, "R10 holding buffer refilled");

    // R7 sticky
    wr(3'd0, 8'hA4);
    rd(3'd0, 8'hA4, "R7 writing one keeps done");
    wr(3'd0, 8'h84);
    rd(3'd0, 8'h84, "R7 writing zero clears done");

    // R4 R6 data erase with exact timing
    wr(3'd0, 8'h14);
    unlock_go(8'h16);
    pin(K_BUSY, 1, "R6 busy first cycle");
    pin(K_TGT, 0, "R3 data target");
    pin(K_ERS, 1, "R4 erase strobe");
    pin(K_WR, 0, "R4 no write strobe during erase");
    pin(K_ADDR, 64'h01234D, "R3 data address is full pointer");
    idle(OPC - 7);
    pin(K_BUSY, 1, "R6 busy last cycle");
    pin(K_BUSY, 0, "R6 busy ends after OP_CYCLES");
    pin(K_IRQ, 1, "R7 done after erase");
    rd(3'd0, 8'h34, "R7 R6 ctrl after erase");

    // R3 configuration override, R8 warm reset mid-operation
    wr(3'd0, 8'hC4);
    unlock_go(8'hC6);
    pin(K_TGT, 2, "R3 configuration overrides program select");
    pin(K_WR, 1, "R4 write strobe to configuration");
    pin(K_WDAT, 64'h17, "R3 latch to configuration");
    warm_pulse();
    rd(3'd0, 8'h08, "R8 error flag after warm reset");
    pin(K_BUSY, 0, "R8 operation aborted");
    rd(3'd2, 8'h00, "R8 latch zeroed");
    rd(3'd4, 8'h00, "R8 pointer low zeroed");
    rd(3'd6, 8'h00, "R8 pointer high zeroed");
    rd(3'd3, 8'hFF, "R8 holding buffer refilled");
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h08, "R8 error flag sticky under write one");
    wr(3'd0, 8'h00);
    rd(3'd0, 8'h00, "R8 error flag cleared by write zero");
    warm_pulse();
    rd(3'd0, 8'h00, "R8 idle warm reset leaves error clear");

    idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule